// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds one packed 32-bit configuration word for each of a set of general-purpose pads (128 by default). Each word carries the value driven onto the pad, a read-only copy of the pad level after synchronization, separate disable bits for the transmitter and the receiver, and a four-bit receive interrupt mode that a separate interrupt block decodes. The block drives every pad's output and output-enable straight from the stored words, and it samples every pad input through a two-flop synchronizer.

Software finds the pad array by reading a pointer word at offset 0. The pad words sit at that base plus four bytes per pad. A protection bitmap is captured from an input port while reset is asserted. It can be read as a short run of words just after the pointer, and every set bit turns the matching pad word into a read-only word. Access uses a plain 32-bit register port with no byte enables. A read request returns data on the following cycle, and a write produces no response. There is no back-pressure: every request is taken in the cycle it is presented.

Top module: `gpio_pad_bank`

## Requirements
- R1: A read of byte address 0x000 returns the pad-array base offset, which is 0x200 by default.
- R2: The word for pad i sits at base + 4*i. A write stores bit 0 (drive value), bit 3 (transmit disable), bit 4 (receive disable) and bits 25:22 (receive mode). All other bits read back as 0.
- R3: After reset every pad word reads 0x0000_0008, with only transmit disable set and pad inputs low, and every pad_oe and pad_out is 0.
- R4: pad_out[i] equals bit 0 of pad word i and pad_oe[i] equals the inverse of bit 3. Both take a written value on the clock edge that accepts the write.
- R5: Bit 1 reads pad_in[i] through two synchronizing flops, so a change shows up in reads issued three or more cycles later. It reads 0 whenever bit 4 is set, and a write to bit 1 has no effect.
- R6: While rst_n is low, lock_init is captured into the protection bitmap, which then stays fixed. Word k of the bitmap reads at byte address 0x004 + 4*k, and bit j of that word belongs to pad 32*k + j. Writes to these words are ignored.
- R7: A write to a pad whose protection bit is set is ignored. A read of that pad still returns its current contents.
- R8: A request with req_valid=1 and req_write=0 gives rsp_valid=1 with its data on the next cycle. A write or an idle cycle gives rsp_valid=0 on the next cycle.
- R9: Reads of unaligned addresses and of addresses outside the pointer, bitmap and pad ranges return 0. Writes to them, and to the pointer word, change nothing.
- R10: The receive mode field stores and returns any 4-bit value, including the codes 0 (level), 1 (edge) and 2 (disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_init | input | 128 | Protection bitmap sampled while reset is low |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 128 | Asynchronous pad input levels |
| pad_out | output | 128 | Pad drive values |
| pad_oe | output | 128 | Pad output enables |

## Verification
The assertions assume that lock_init is steady for the whole reset window, and that every request is a single-cycle pulse whose address and data are valid whenever req_valid is high. They also assume that reset is held long enough for the bitmap to be captured. The stimulus sets lock_init before time zero and never changes it. It presents each request for exactly one cycle, driven between clock edges. It changes pad_in only while no read is pending and then waits three cycles before it reads, so each expected bit-1 value is the settled input level.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned TX_BIT    = 0;
  localparam int unsigned RX_BIT    = 1;
  localparam int unsigned TXDIS_BIT = 3;
  localparam int unsigned RXDIS_BIT = 4;
  localparam int unsigned MODE_LSB  = 22;
  localparam int unsigned MODE_W    = 4;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              rxdis;
    logic              txdis;
    logic              tx;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RESET = '{mode: '0, rxdis: 1'b0, txdis: 1'b1, tx: 1'b0};

  function automatic pad_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    pad_cfg_t c;
    c.tx    = w[TX_BIT];
    c.txdis = w[TXDIS_BIT];
    c.rxdis = w[RXDIS_BIT];
    c.mode  = w[MODE_LSB +: MODE_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input pad_cfg_t c, input logic rx);
    logic [WORD_W-1:0] w;
    w                      = '0;
    w[TX_BIT]              = c.tx;
    w[RX_BIT]              = rx & ~c.rxdis;
    w[TXDIS_BIT]           = c.txdis;
    w[RXDIS_BIT]           = c.rxdis;
    w[MODE_LSB +: MODE_W]  = c.mode;
    return w;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PADS = 128,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] rx_sync
);
  logic [NUM_PADS-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= pad_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign rx_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_store.sv
module gpio_cfg_store
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NUM_PADS = 128,
  parameter int unsigned IDX_W    = $clog2(NUM_PADS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PADS-1:0]        lock_init,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WORD_W-1:0]          wr_word,
  output logic [NUM_PADS-1:0]        lock_q,
  output pad_cfg_t [NUM_PADS-1:0]    cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= lock_init;
  end

  // R6
  lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lock_q));

  generate
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i)) && !lock_q[i];

      always_ff @(posedge clk) begin
        if (!rst_n)   cfg_q[i] <= CFG_RESET;
        else if (hit) cfg_q[i] <= word_to_cfg(wr_word);
      end

      // R7
      locked_pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[i] |=> $stable(cfg_q[i]));
    end
  endgenerate
endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NUM_PADS   = 128,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned PAD_BASE   = 32'h200,
  parameter int unsigned IDX_W      = $clog2(NUM_PADS),
  parameter int unsigned LOCK_WORDS = (NUM_PADS + 31) / 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [WORD_W-1:0]       req_wdata,
  input  pad_cfg_t [NUM_PADS-1:0] cfg_q,
  input  logic [NUM_PADS-1:0]     lock_q,
  input  logic [NUM_PADS-1:0]     rx_sync,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [WORD_W-1:0]       wr_word,
  output logic                    rsp_valid,
  output logic [WORD_W-1:0]       rsp_rdata
);
  localparam int unsigned LOCK_BASE = 4;
  localparam int unsigned LSEL_W    = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam int unsigned LOCK_EXT  = LOCK_WORDS * 32;

  logic [31:0]          addr32;
  logic                 aligned, ptr_hit, lock_hit, pad_hit, rd_req;
  logic [IDX_W-1:0]     pad_idx;
  logic [LSEL_W-1:0]    lock_sel;
  logic [LOCK_EXT-1:0]  lock_ext;
  logic [WORD_W-1:0]    rd_next;

  assign addr32   = 32'(req_addr);
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign ptr_hit  = (addr32 == 32'd0);
  assign lock_hit = aligned && (addr32 >= LOCK_BASE) && (addr32 < LOCK_BASE + 4 * LOCK_WORDS);
  assign pad_hit  = aligned && (addr32 >= PAD_BASE) && (addr32 < PAD_BASE + 4 * NUM_PADS);
  assign pad_idx  = IDX_W'((addr32 - PAD_BASE) >> 2);
  assign lock_sel = LSEL_W'((addr32 - LOCK_BASE) >> 2);
  assign lock_ext = LOCK_EXT'(lock_q);
  assign rd_req   = req_valid && !req_write;

  assign wr_en   = req_valid && req_write && pad_hit;
  assign wr_idx  = pad_idx;
  assign wr_word = req_wdata;

  always_comb begin
    rd_next = '0;
    if (ptr_hit)       rd_next = WORD_W'(PAD_BASE);
    else if (lock_hit) rd_next = lock_ext[32*lock_sel +: 32];
    else if (pad_hit)  rd_next = cfg_to_word(cfg_q[pad_idx], rx_sync[pad_idx]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_next;
    end
  end

  // R8
  read_gets_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  // R8
  no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  // R1
  pointer_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && ptr_hit) |=> (rsp_rdata == WORD_W'(PAD_BASE)));
  // R5
  rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && pad_hit && cfg_q[pad_idx].rxdis) |=> !rsp_rdata[RX_BIT]);
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !ptr_hit && !lock_hit && !pad_hit) |=> (rsp_rdata == '0));
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter int unsigned NUM_PADS = 128,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned PAD_BASE = 32'h200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] lock_init,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe
);
  localparam int unsigned IDX_W = $clog2(NUM_PADS);

  pad_cfg_t [NUM_PADS-1:0] cfg_q;
  logic [NUM_PADS-1:0]     lock_q;
  logic [NUM_PADS-1:0]     rx_sync;
  logic                    wr_en;
  logic [IDX_W-1:0]        wr_idx;
  logic [WORD_W-1:0]       wr_word;

  gpio_in_sync #(.NUM_PADS(NUM_PADS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .rx_sync(rx_sync)
  );

  gpio_cfg_store #(.NUM_PADS(NUM_PADS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .lock_init(lock_init),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .lock_q(lock_q), .cfg_q(cfg_q)
  );

  gpio_bus_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .PAD_BASE(PAD_BASE), .IDX_W(IDX_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_q(cfg_q), .lock_q(lock_q), .rx_sync(rx_sync),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_PADS; i++) begin : g_drive
      assign pad_out[i] = cfg_q[i].tx;
      assign pad_oe[i]  = ~cfg_q[i].txdis;
    end
  endgenerate

  // R4
  pad_drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q[wr_idx]) |=>
      (pad_out[$past(wr_idx)] == $past(wr_word[TX_BIT])) &&
      (pad_oe[$past(wr_idx)] == !$past(wr_word[TXDIS_BIT])));
endmodule

// File: tb/sim_gpio_pad_bank.sv
`timescale 1ns/1ps
module sim_gpio_pad_bank;
  localparam int N = 128;
  localparam logic [31:0] WMASK = 32'h03C0_0019;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lock_init = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [9:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] m_cfg [N];

  always #2.5 clk = ~clk;

  gpio_pad_bank u0 (
    .clk(clk), .rst_n(rst_n), .lock_init(lock_init),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] expect_rd(input logic [9:0] a);
    int ai = int'(a);
    logic [31:0] w;
    if (ai == 0) return 32'h200;
    if (a[1:0] != 2'b00) return 32'h0;
    if (ai >= 4 && ai < 20) return lock_init[32*((ai-4)/4) +: 32];
    if (ai >= 32'h200) begin
      w = m_cfg[(ai - 32'h200) / 4];
      if (!w[4]) w[1] = pad_in[(ai - 32'h200) / 4];
      return w;
    end
    return 32'h0;
  endfunction

  function automatic logic [9:0] pad_addr(input int i);
    return 10'(32'h200 + 4 * i);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic do_read(input logic [9:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    e = expect_rd(a);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R8 rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(tag, rsp_rdata, e);
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    int ai = int'(a);
    int idx;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 no response to write", 32'(rsp_valid), 32'd0);
    if (ai >= 32'h200 && a[1:0] == 2'b00) begin
      idx = (ai - 32'h200) / 4;
      if (!lock_init[idx]) m_cfg[idx] = d & WMASK;
      check("R4 pad_out", 32'(pad_out[idx]), 32'(m_cfg[idx][0]));
      check("R4 pad_oe", 32'(pad_oe[idx]), 32'(!m_cfg[idx][3]));
    end
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unlocked_pad, locked_pad;
    void'($urandom(32'd2718));
    lock_init = {$urandom, $urandom, $urandom, $urandom};
    lock_init[0] = 1'b0;
    lock_init[1] = 1'b1;
    for (int i = 0; i < N; i++) m_cfg[i] = 32'h8;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    @(negedge clk);
    check("R3 pad_oe after reset", 32'(|pad_oe), 32'd0);
    check("R3 pad_out after reset", 32'(|pad_out), 32'd0);
    for (int i = 0; i < N; i++) do_read(pad_addr(i), "R3 reset word");

    // R1 pointer, R6 bitmap words
    do_read(10'h000, "R1 pointer word");
    for (int k = 0; k < 4; k++) do_read(10'(4 + 4 * k), "R6 lock word");

    // R2/R4: unlocked pad 0, full word write
    do_write(pad_addr(0), 32'hFFFF_FFFF);
    do_read(pad_addr(0), "R2 writable mask");
    do_write(pad_addr(0), 32'h0000_0001);
    do_read(pad_addr(0), "R4 drive enabled");
    check("R4 pad_oe on", 32'(pad_oe[0]), 32'd1);
    check("R4 pad_out on", 32'(pad_out[0]), 32'd1);

    // R10: mode codes
    for (int m = 0; m < 16; m++) begin
      do_write(pad_addr(0), 32'(m) << 22);
      do_read(pad_addr(0), "R10 mode field");
    end

    // R5: synchronized input, gating by receive disable, write to bit 1 ignored
    set_pins(N'(1));
    do_write(pad_addr(0), 32'h0000_0008);
    do_read(pad_addr(0), "R5 input visible");
    do_write(pad_addr(0), 32'h0000_0010);
    do_read(pad_addr(0), "R5 receiver disabled");
    set_pins('0);
    do_write(pad_addr(0), 32'h0000_0002);
    do_read(pad_addr(0), "R5 bit1 not writable");

    // R7: locked pad 1
    do_write(pad_addr(1), 32'h03C0_0011);
    do_read(pad_addr(1), "R7 locked pad unchanged");
    check("R7 locked pad_oe", 32'(pad_oe[1]), 32'd0);

    // R9 / R6: writes outside pad region
    do_write(10'h000, 32'h1234_5678);
    do_read(10'h000, "R9 pointer unchanged");
    do_write(10'h004, 32'hFFFF_FFFF);
    do_read(10'h004, "R6 lock word read-only");
    do_read(10'h100, "R9 unmapped read");
    do_read(pad_addr(5) + 10'd2, "R9 unaligned read");
    do_write(pad_addr(5) + 10'd1, 32'h0000_0001);
    do_read(pad_addr(5), "R9 unaligned write ignored");

    // Random mixed traffic
    for (int it = 0; it < 3000; it++) begin
      int op = int'($urandom % 6);
      int p  = int'($urandom % N);
      case (op)
        0, 1: do_write(pad_addr(p), $urandom);
        2, 3: do_read(pad_addr(p), "R2 R7 random pad read");
        4:    do_read(10'($urandom), "R9 random address read");
        default: begin
          if ($urandom % 2 == 0) set_pins({$urandom, $urandom, $urandom, $urandom});
          else do_write(10'($urandom), $urandom);
        end
      endcase
    end

    // final sweep of all pad words and pins
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      do_read(pad_addr(i), "R5 R7 final sweep");
      check("R4 final pad_out", 32'(pad_out[i]), 32'(m_cfg[i][0]));
      check("R4 final pad_oe", 32'(pad_oe[i]), 32'(!m_cfg[i][3]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule